// File: doc/BRIEF.md
# Prioritized Next Fetch Address Selector

This block decides, once per clock, where instruction fetch goes next. It holds the current fetch address in a register and picks the next one from a fixed ranking. An exception comes first. Mispredict recoveries come next, ranked by the stage that found them: execute, then dispatch, then decode. A hit in a small branch target address cache (BTAC) comes after those. When nothing else applies, the address moves forward by one sequential fetch block.

The fetch address goes to the instruction cache together with a valid flag. The cache answers with an accept strobe. While the cache does not accept, the address stays where it is, although any redirect still replaces it. In the same cycle as a redirect, the block raises a flush indication so that downstream stages know which instructions to discard. The BTAC is direct-mapped. It is looked up with the current fetch address and filled or cleared through an update port driven by branch resolution.

Top module: `nfa_selector`

## Requirements
- R1: While `rst` is high, `fetchAddr` equals `RESET_VECTOR` (default 0x400) and `fetchValid` is 0. From the first clock edge after `rst` is released, `fetchValid` is 1. Reset invalidates every BTAC entry, so an entry written before reset cannot produce a hit after it.
- R2: When `excReq` is high, `fetchAddr` becomes `excVector` at the next clock edge, whatever the other inputs are, and `flushAll` is high in that cycle.
- R3: Without an exception, `exeRecover` outranks `dispRecover`, which outranks `decRecover`. The winner's target is loaded at the next edge. An execute-stage recovery raises `flushAll`, meaning all undispatched instructions are discarded.
- R4: A dispatch-stage recovery that wins raises `flushDisp`, and a decode-stage recovery that wins raises `flushDec`. Each of these discards only the instructions younger than the branch.
- R5: At most one of `flushAll`, `flushDisp` and `flushDec` is high in any cycle. All three are low when no exception or recovery is requested.
- R6: With no redirect and `fetchAccept` high, a BTAC hit on the current `fetchAddr` loads the stored target at the next edge. Any pending redirect beats the hit.
- R7: With no redirect, `fetchAccept` high and no BTAC hit, `fetchAddr` advances by 16 bytes, which is one block of four 32-bit instructions.
- R8: With no redirect and `fetchAccept` low, `fetchAddr` holds, even when the BTAC hits.
- R9: The BTAC has 16 entries. The entry index is address bits [7:4] and the partial tag is bits [15:8]. An entry whose index matches but whose tag differs is a miss.
- R10: An update with `updValid` high and `updTaken` high writes tag and target into the entry selected by `updAddr`. With `updTaken` low, it invalidates that entry. The change affects lookups from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| excReq | input | 1 | Exception redirect request |
| excVector | input | 32 | Exception vector address |
| exeRecover | input | 1 | Mispredict recovery from the execute stage |
| exeTarget | input | 32 | Corrected target from execute |
| dispRecover | input | 1 | Mispredict recovery from the dispatch stage |
| dispTarget | input | 32 | Corrected target from dispatch |
| decRecover | input | 1 | Mispredict recovery from the decode stage |
| decTarget | input | 32 | Corrected target from decode |
| updValid | input | 1 | BTAC update strobe |
| updTaken | input | 1 | 1 writes the entry, 0 invalidates it |
| updAddr | input | 32 | Fetch address of the resolved branch block |
| updTarget | input | 32 | Target to store |
| fetchAccept | input | 1 | Instruction cache accepted the current fetch |
| fetchAddr | output | 32 | Current fetch address |
| fetchValid | output | 1 | Fetch address is valid |
| flushAll | output | 1 | Discard all undispatched instructions |
| flushDisp | output | 1 | Discard instructions younger than the dispatch-stage branch |
| flushDec | output | 1 | Discard instructions younger than the decode-stage branch |

## Verification
The assertions take for granted that every request input is a clean, fully defined level that is sampled only at clock edges. They also assume that the target and vector buses are stable while their request is high. Several requests may be high at once, because settling that overlap is the block's own job. The bench drives every input at the falling edge, holds it for a whole cycle and returns the requests to low between steps. Each recovery target is set explicitly before the request that uses it is raised. BTAC updates are made on cycles in which the updated entry is not the one being looked up, so no property depends on a same-cycle write and read of one entry.

// File: rtl/nfa_pkg.sv
package nfa_pkg;
  typedef enum logic [2:0] {
    SEL_HOLD = 3'd0,
    SEL_SEQ  = 3'd1,
    SEL_BTAC = 3'd2,
    SEL_EXC  = 3'd3,
    SEL_EXE  = 3'd4,
    SEL_DISP = 3'd5,
    SEL_DEC  = 3'd6
  } nextSrc_e;

  typedef struct packed {
    nextSrc_e sel;
  } ctrlStrobes_t;
endpackage

// File: rtl/nfa_ctrl.sv
module nfa_ctrl
  import nfa_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         excReq,
  input  logic         exeRecover,
  input  logic         dispRecover,
  input  logic         decRecover,
  input  logic         fetchAccept,
  input  logic         btacHit,
  output ctrlStrobes_t strobes,
  output logic         flushAll,
  output logic         flushDisp,
  output logic         flushDec
);
  always_comb begin
    strobes.sel = SEL_HOLD;
    flushAll    = 1'b0;
    flushDisp   = 1'b0;
    flushDec    = 1'b0;
    if (excReq) begin
      strobes.sel = SEL_EXC;
      flushAll    = 1'b1;
    end else if (exeRecover) begin
      strobes.sel = SEL_EXE;
      flushAll    = 1'b1;
    end else if (dispRecover) begin
      strobes.sel = SEL_DISP;
      flushDisp   = 1'b1;
    end else if (decRecover) begin
      strobes.sel = SEL_DEC;
      flushDec    = 1'b1;
    end else if (fetchAccept) begin
      strobes.sel = btacHit ? SEL_BTAC : SEL_SEQ;
    end
  end

  // R5: never two flush kinds at once
  p_one_flush_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({flushAll, flushDisp, flushDec}));
  // R5: quiet when no redirect is requested
  p_no_flush_r5: assert property (@(posedge clk) disable iff (rst)
    !(excReq || exeRecover || dispRecover || decRecover) |-> !(flushAll || flushDisp || flushDec));
  // R2: an exception always discards everything
  p_exc_flush_r2: assert property (@(posedge clk) disable iff (rst)
    excReq |-> flushAll);
  // R3: execute outranks the younger-only flushes
  p_exe_rank_r3: assert property (@(posedge clk) disable iff (rst)
    exeRecover |-> (flushAll && !flushDisp && !flushDec));
endmodule

// File: rtl/nfa_datapath.sv
module nfa_datapath
  import nfa_pkg::*;
#(
  parameter int          ADDR_W       = 32,
  parameter int          IDX_W        = 4,
  parameter int          TAG_W        = 8,
  parameter int          BLOCK_BYTES  = 16,
  parameter logic [31:0] RESET_VECTOR = 32'h0000_0400
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] excVector,
  input  logic [ADDR_W-1:0] exeTarget,
  input  logic [ADDR_W-1:0] dispTarget,
  input  logic [ADDR_W-1:0] decTarget,
  input  logic              updValid,
  input  logic              updTaken,
  input  logic [ADDR_W-1:0] updAddr,
  input  logic [ADDR_W-1:0] updTarget,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              fetchValid,
  output logic              btacHit
);
  localparam int OFF_W   = $clog2(BLOCK_BYTES);
  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BLOCK_BYTES);

  logic [ENTRIES-1:0] entValid;
  logic [TAG_W-1:0]   entTag [ENTRIES];
  logic [ADDR_W-1:0]  entTgt [ENTRIES];

  logic [IDX_W-1:0] updIdx, lkIdx;
  logic [TAG_W-1:0] updTag, lkTag;
  assign updIdx = updAddr[OFF_W +: IDX_W];
  assign updTag = updAddr[OFF_W+IDX_W +: TAG_W];
  assign lkIdx  = fetchAddr[OFF_W +: IDX_W];
  assign lkTag  = fetchAddr[OFF_W+IDX_W +: TAG_W];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic              vReg;
    logic [TAG_W-1:0]  tagReg;
    logic [ADDR_W-1:0] tgtReg;
    logic              sel;
    assign sel = updValid && (updIdx == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (rst) vReg <= 1'b0;
      else if (sel) vReg <= updTaken;
    end
    always_ff @(posedge clk) begin
      if (sel && updTaken) begin
        tagReg <= updTag;
        tgtReg <= updTarget;
      end
    end
    assign entValid[e] = vReg;
    assign entTag[e]   = tagReg;
    assign entTgt[e]   = tgtReg;
  end

  assign btacHit = entValid[lkIdx] && (entTag[lkIdx] == lkTag);

  logic [ADDR_W-1:0] nextAddr;
  always_comb begin
    unique case (strobes.sel)
      SEL_EXC:  nextAddr = excVector;
      SEL_EXE:  nextAddr = exeTarget;
      SEL_DISP: nextAddr = dispTarget;
      SEL_DEC:  nextAddr = decTarget;
      SEL_BTAC: nextAddr = entTgt[lkIdx];
      SEL_SEQ:  nextAddr = fetchAddr + STEP;
      default:  nextAddr = fetchAddr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fetchAddr  <= ADDR_W'(RESET_VECTOR);
      fetchValid <= 1'b0;
    end else begin
      fetchAddr  <= nextAddr;
      fetchValid <= 1'b1;
    end
  end

  // R1: reset restores the start address
  p_reset_vec_r1: assert property (@(posedge clk)
    rst |=> fetchAddr == ADDR_W'(RESET_VECTOR));
  // R2: exception vector lands one edge later
  p_exc_vec_r2: assert property (@(posedge clk) disable iff (rst)
    strobes.sel == SEL_EXC |=> fetchAddr == $past(excVector));
  // R7: sequential step is one block
  p_seq_step_r7: assert property (@(posedge clk) disable iff (rst)
    strobes.sel == SEL_SEQ |=> fetchAddr == $past(fetchAddr) + STEP);
  // R8: no accept and no redirect keeps the address
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    strobes.sel == SEL_HOLD |=> $stable(fetchAddr));
  // R10: an invalidating update removes the hit for that address
  p_inval_r10: assert property (@(posedge clk) disable iff (rst)
    (updValid && !updTaken && updAddr[OFF_W+IDX_W-1:OFF_W] == lkIdx && $stable(fetchAddr))
      |=> !btacHit || !$stable(fetchAddr));
endmodule

// File: rtl/nfa_selector.sv
module nfa_selector
  import nfa_pkg::*;
#(
  parameter int          ADDR_W       = 32,
  parameter int          IDX_W        = 4,
  parameter int          TAG_W        = 8,
  parameter int          BLOCK_BYTES  = 16,
  parameter logic [31:0] RESET_VECTOR = 32'h0000_0400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              excReq,
  input  logic [ADDR_W-1:0] excVector,
  input  logic              exeRecover,
  input  logic [ADDR_W-1:0] exeTarget,
  input  logic              dispRecover,
  input  logic [ADDR_W-1:0] dispTarget,
  input  logic              decRecover,
  input  logic [ADDR_W-1:0] decTarget,
  input  logic              updValid,
  input  logic              updTaken,
  input  logic [ADDR_W-1:0] updAddr,
  input  logic [ADDR_W-1:0] updTarget,
  input  logic              fetchAccept,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              fetchValid,
  output logic              flushAll,
  output logic              flushDisp,
  output logic              flushDec
);
  ctrlStrobes_t strobes;
  logic         btacHit;

  nfa_ctrl u_ctrl (
    .clk(clk), .rst(rst), .excReq(excReq), .exeRecover(exeRecover),
    .dispRecover(dispRecover), .decRecover(decRecover),
    .fetchAccept(fetchAccept), .btacHit(btacHit), .strobes(strobes),
    .flushAll(flushAll), .flushDisp(flushDisp), .flushDec(flushDec)
  );

  nfa_datapath #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W),
    .BLOCK_BYTES(BLOCK_BYTES), .RESET_VECTOR(RESET_VECTOR)
  ) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .excVector(excVector),
    .exeTarget(exeTarget), .dispTarget(dispTarget), .decTarget(decTarget),
    .updValid(updValid), .updTaken(updTaken), .updAddr(updAddr),
    .updTarget(updTarget), .fetchAddr(fetchAddr), .fetchValid(fetchValid),
    .btacHit(btacHit)
  );
endmodule

// File: tb/nfa_selector_test.sv
module nfa_selector_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, excReq, exeRecover, dispRecover, decRecover;
  logic        updValid, updTaken, fetchAccept;
  logic [31:0] excVector, exeTarget, dispTarget, decTarget, updAddr, updTarget;
  logic [31:0] fetchAddr;
  logic        fetchValid, flushAll, flushDisp, flushDec;

  int checks = 0;
  int fails  = 0;

  nfa_selector uut (.*);

  // {exc, exe, disp, dec, accept, flushCode[1:0], expected next address}
  // flushCode: 0 none, 1 all, 2 dispatch-younger, 3 decode-younger
  localparam int NV = 8;
  localparam logic [38:0] VEC [NV] = '{
    {5'b00001, 2'd0, 32'h0000_0410},  // R7
    {5'b00000, 2'd0, 32'h0000_0410},  // R8
    {5'b00011, 2'd3, 32'h0000_4000},  // R4
    {5'b00110, 2'd2, 32'h0000_3000},  // R3
    {5'b01110, 2'd1, 32'h0000_2000},  // R3
    {5'b11111, 2'd1, 32'h0000_0100},  // R2
    {5'b00001, 2'd0, 32'h0000_0110},  // R7
    {5'b01000, 2'd1, 32'h0000_2000}   // R8 redirect overrides hold
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearIn();
    excReq = 0; exeRecover = 0; dispRecover = 0; decRecover = 0;
    updValid = 0; updTaken = 0; fetchAccept = 0;
  endtask

  function automatic logic [1:0] flushCode();
    return flushAll ? 2'd1 : flushDisp ? 2'd2 : flushDec ? 2'd3 : 2'd0;
  endfunction

  // one step: inputs already driven after a falling edge
  task automatic step(input string req, input logic [1:0] expFl, input logic [31:0] expAddr);
    #1;
    chk({req, " flush"}, {30'd0, flushCode()}, {30'd0, expFl});
    chk({req, " R5 onehot"}, {31'd0, $onehot0({flushAll, flushDisp, flushDec})}, 32'd1);
    @(negedge clk);
    chk({req, " addr"}, fetchAddr, expAddr);
    clearIn();
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    clearIn();
    excVector = 32'h100; exeTarget = 32'h2000; dispTarget = 32'h3000; decTarget = 32'h4000;
    updAddr = 0; updTarget = 0;
    rst = 1;
    repeat (2) @(negedge clk);
    chk("R1 reset addr", fetchAddr, 32'h400);
    chk("R1 valid low", {31'd0, fetchValid}, 32'd0);
    rst = 0;
    @(negedge clk);
    chk("R1 valid high", {31'd0, fetchValid}, 32'd1);
    chk("R5 idle flush", {30'd0, flushCode()}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      {excReq, exeRecover, dispRecover, decRecover, fetchAccept} = VEC[i][38:34];
      step($sformatf("vec%0d", i), VEC[i][33:32], VEC[i][31:0]);
    end

    // R10: write entry for 0x2010 -> 0x5000 while holding at 0x2000
    updValid = 1; updTaken = 1; updAddr = 32'h2010; updTarget = 32'h5000;
    step("R10 write/R8 hold", 2'd0, 32'h2000);
    fetchAccept = 1;
    step("R7 miss at 0x2000", 2'd0, 32'h2010);
    step("R8 hold on hit", 2'd0, 32'h2010);
    decRecover = 1; decTarget = 32'h2010; fetchAccept = 1;
    step("R6 redirect beats hit", 2'd3, 32'h2010);
    fetchAccept = 1;
    step("R6 hit taken", 2'd0, 32'h5000);
    fetchAccept = 1;
    step("R7 seq", 2'd0, 32'h5010);
    fetchAccept = 1;
    step("R9 tag mismatch", 2'd0, 32'h5020);
    // R10: invalidate the entry while redirecting back to it
    updValid = 1; updTaken = 0; updAddr = 32'h2010; exeRecover = 1; exeTarget = 32'h2010;
    step("R10 invalidate", 2'd1, 32'h2010);
    fetchAccept = 1;
    step("R10 entry gone", 2'd0, 32'h2020);

    // R1: entry written before reset must be forgotten
    updValid = 1; updTaken = 1; updAddr = 32'h400; updTarget = 32'h7000;
    step("R1 pre-reset write", 2'd0, 32'h2020);
    rst = 1;
    repeat (2) @(negedge clk);
    chk("R1 reset addr again", fetchAddr, 32'h400);
    rst = 0;
    fetchAccept = 1;
    step("R1 btac cleared", 2'd0, 32'h410);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule